// File: doc/BRIEF.md
# Unconditional Control-Transfer Target Generator

This block takes one unconditional control transfer that has already been decoded and computes where execution goes next: a new code-segment value, a new 16-bit instruction pointer, and a flag that says whether the segment is replaced. It handles six kinds of transfer. Two are relative: an 8-bit or 16-bit signed displacement is added to the address of the following instruction. One is a direct far form that carries a new offset and a new segment inside the instruction. Three are indirect: a register value, a fetched 16-bit table entry, or a fetched 32-bit table entry holding offset and segment.

The arithmetic is a single combinational path. Its result is captured in an output register stage that is steered by a two-state issue machine. The machine has two states. `ST_IDLE` means no result is being presented. `ST_ISSUE` means a result captured on the previous edge is on the outputs with `out_valid` high. An accepted request (valid strobe high and a legal kind) moves the machine from `ST_IDLE` to `ST_ISSUE` (transition ACCEPT). It stays in `ST_ISSUE` on back-to-back accepts (transition REISSUE). It returns to `ST_IDLE` on any cycle without an accept (transition DRAIN).

Instruction fetch, decoding, the memory reads for indirect tables, and any descriptor lookup happen upstream. Indirect operands reach the block already fetched.

Top module: `jump_target_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `cs_changed`, `new_cs` and `new_ip` are all zero.
- R2: Kind code 0 (two-byte short form): `new_ip` = `cur_ip` + 2 + the sign-extended byte `imm_bytes[7:0]`, `new_cs` = `cur_cs`, and `cs_changed` = 0.
- R3: Kind code 1 (three-byte near form): `new_ip` = `cur_ip` + 3 + the 16-bit signed value {`imm_bytes[15:8]`, `imm_bytes[7:0]`}, with the low byte being the one next to the opcode. `new_cs` = `cur_cs` and `cs_changed` = 0.
- R4: Kind code 2 (five-byte direct far form): `new_ip` = `imm_bytes[15:0]` and `new_cs` = `imm_bytes[31:16]`, each little-endian. `cs_changed` = 1.
- R5: Kind code 3 (register form): `new_ip` = `operand[15:0]` with no addition to `cur_ip`, and `operand[31:16]` has no effect. `new_cs` = `cur_cs` and `cs_changed` = 0.
- R6: Kind code 4 (fetched near table entry): `new_ip` = `operand[15:0]`, `new_cs` = `cur_cs`, and `cs_changed` = 0.
- R7: Kind code 5 (fetched far table entry): `new_ip` = `operand[15:0]`, `new_cs` = `operand[31:16]`, and `cs_changed` = 1.
- R8: All relative offset arithmetic wraps modulo 2^16. A target that crosses FFFFH or 0000H stays inside the current segment.
- R9: `out_valid` is high exactly one cycle after a cycle in which `in_valid` is high with a legal kind. While no request is accepted, `new_cs`, `new_ip` and `cs_changed` hold their values.
- R10: Kind codes 6 and 7 are reserved. A request that carries them is ignored: `out_valid` is low on the following cycle and the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| kind | input | 3 | Transfer kind code (0..5 legal, 6..7 reserved) |
| cur_cs | input | 16 | Current code-segment value |
| cur_ip | input | 16 | Instruction pointer of the transfer instruction itself |
| imm_bytes | input | 32 | Instruction bytes after the opcode; the first such byte is at [7:0] |
| operand | input | 32 | Register value or fetched table entry (offset low, segment high) |
| out_valid | output | 1 | Result present on the outputs |
| new_cs | output | 16 | Target code-segment value |
| new_ip | output | 16 | Target instruction pointer |
| cs_changed | output | 1 | High when the target replaces the code segment |

## Verification
The hardest situations to reach are those where a wrong design would leave no trace on a plain forward jump. One is an offset sum that crosses the segment boundary in either direction. The other is a reserved kind code arriving with a high strobe while stale results sit on the outputs. The vector table places short and near transfers at FFFEH, FFF0H and 0001H, with displacements chosen so that the sum wraps upward or downward. A directed step then sends reserved codes with changed operands directly after a far result, so that any unwanted capture would change the held segment or flag.

// File: rtl/jtg_pkg.sv
package jtg_pkg;

    typedef enum logic [2:0] {
        JK_SHORT    = 3'd0,
        JK_NEAR     = 3'd1,
        JK_FAR      = 3'd2,
        JK_REG      = 3'd3,
        JK_MEM_NEAR = 3'd4,
        JK_MEM_FAR  = 3'd5,
        JK_RSV6     = 3'd6,
        JK_RSV7     = 3'd7
    } jump_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } issue_state_e;

    localparam int unsigned SHORT_LEN = 2;

    function automatic logic kind_is_legal(input jump_kind_e k);
        return (k != JK_RSV6) && (k != JK_RSV7);
    endfunction

    function automatic logic kind_is_relative(input jump_kind_e k);
        return (k == JK_SHORT) || (k == JK_NEAR);
    endfunction

endpackage

// File: rtl/jtg_rel_unit.sv
module jtg_rel_unit
    import jtg_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             is_short,
    input  logic [OFS_W-1:0] cur_ip,
    input  logic [OFS_W-1:0] disp_field,
    output logic [OFS_W-1:0] rel_ip
);
    localparam int DISP_BYTES = OFS_W / 8;
    localparam int NEAR_LEN   = 1 + DISP_BYTES;

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] next_ip;

    always_comb begin
        if (is_short) begin
            disp_ext = {{(OFS_W-8){disp_field[7]}}, disp_field[7:0]};
            next_ip  = cur_ip + OFS_W'(SHORT_LEN);
        end else begin
            disp_ext = disp_field;
            next_ip  = cur_ip + OFS_W'(NEAR_LEN);
        end
        rel_ip = next_ip + disp_ext;
    end

endmodule

// File: rtl/jtg_abs_unit.sv
module jtg_abs_unit
    import jtg_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int SEG_W = 16
) (
    input  jump_kind_e             kind,
    input  logic [SEG_W-1:0]       cur_cs,
    input  logic [OFS_W+SEG_W-1:0] imm_bytes,
    input  logic [OFS_W+SEG_W-1:0] operand,
    output logic [OFS_W-1:0]       abs_ip,
    output logic [SEG_W-1:0]       abs_cs,
    output logic                   abs_far
);

    always_comb begin
        abs_ip  = '0;
        abs_cs  = cur_cs;
        abs_far = 1'b0;
        unique case (kind)
            JK_FAR: begin
                abs_ip  = imm_bytes[OFS_W-1:0];
                abs_cs  = imm_bytes[OFS_W +: SEG_W];
                abs_far = 1'b1;
            end
            JK_REG, JK_MEM_NEAR: begin
                abs_ip = operand[OFS_W-1:0];
            end
            JK_MEM_FAR: begin
                abs_ip  = operand[OFS_W-1:0];
                abs_cs  = operand[OFS_W +: SEG_W];
                abs_far = 1'b1;
            end
            default: begin
                abs_ip  = '0;
                abs_cs  = cur_cs;
                abs_far = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/jtg_issue_fsm.sv
module jtg_issue_fsm
    import jtg_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [OFS_W-1:0] tgt_ip,
    input  logic [SEG_W-1:0] tgt_cs,
    input  logic             tgt_far,
    output logic             out_valid,
    output logic [OFS_W-1:0] new_ip,
    output logic [SEG_W-1:0] new_cs,
    output logic             cs_changed
);
    issue_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = accept ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_ip     <= '0;
            new_cs     <= '0;
            cs_changed <= 1'b0;
        end else if (accept) begin
            new_ip     <= tgt_ip;
            new_cs     <= tgt_cs;
            cs_changed <= tgt_far;
        end
    end

    assign out_valid = (state_q == ST_ISSUE);

endmodule

// File: rtl/jump_target_gen.sv
module jump_target_gen
    import jtg_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int SEG_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             kind,
    input  logic [SEG_W-1:0]       cur_cs,
    input  logic [OFS_W-1:0]       cur_ip,
    input  logic [OFS_W+SEG_W-1:0] imm_bytes,
    input  logic [OFS_W+SEG_W-1:0] operand,
    output logic                   out_valid,
    output logic [SEG_W-1:0]       new_cs,
    output logic [OFS_W-1:0]       new_ip,
    output logic                   cs_changed
);
    jump_kind_e       kind_e;
    logic             accept;
    logic [OFS_W-1:0] rel_ip, abs_ip, tgt_ip;
    logic [SEG_W-1:0] abs_cs, tgt_cs;
    logic             abs_far, tgt_far;

    assign kind_e = jump_kind_e'(kind);
    assign accept = in_valid && kind_is_legal(kind_e);

    jtg_rel_unit #(.OFS_W(OFS_W)) u_rel (
        .is_short   (kind_e == JK_SHORT),
        .cur_ip     (cur_ip),
        .disp_field (imm_bytes[OFS_W-1:0]),
        .rel_ip     (rel_ip)
    );

    jtg_abs_unit #(.OFS_W(OFS_W), .SEG_W(SEG_W)) u_abs (
        .kind      (kind_e),
        .cur_cs    (cur_cs),
        .imm_bytes (imm_bytes),
        .operand   (operand),
        .abs_ip    (abs_ip),
        .abs_cs    (abs_cs),
        .abs_far   (abs_far)
    );

    always_comb begin
        if (kind_is_relative(kind_e)) begin
            tgt_ip  = rel_ip;
            tgt_cs  = cur_cs;
            tgt_far = 1'b0;
        end else begin
            tgt_ip  = abs_ip;
            tgt_cs  = abs_cs;
            tgt_far = abs_far;
        end
    end

    jtg_issue_fsm #(.OFS_W(OFS_W), .SEG_W(SEG_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .tgt_ip     (tgt_ip),
        .tgt_cs     (tgt_cs),
        .tgt_far    (tgt_far),
        .out_valid  (out_valid),
        .new_ip     (new_ip),
        .new_cs     (new_cs),
        .cs_changed (cs_changed)
    );

endmodule

// File: rtl/jtg_checker.sv
module jtg_checker #(
    parameter int OFS_W = 16,
    parameter int SEG_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [2:0]             kind,
    input logic [SEG_W-1:0]       cur_cs,
    input logic [OFS_W+SEG_W-1:0] operand,
    input logic                   out_valid,
    input logic [SEG_W-1:0]       new_cs,
    input logic [OFS_W-1:0]       new_ip,
    input logic                   cs_changed
);

    // R9
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind < 3'd6) |=> out_valid);

    // R10
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || kind >= 3'd6) |=> (!out_valid && $stable(new_ip)
                                         && $stable(new_cs) && $stable(cs_changed)));

    // R5
    reg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 3'd3) |=> (new_ip == $past(operand[OFS_W-1:0])
                                        && new_cs == $past(cur_cs) && !cs_changed));

    // R7
    table_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 3'd5) |=> (new_cs == $past(operand[OFS_W +: SEG_W])
                                        && new_ip == $past(operand[OFS_W-1:0]) && cs_changed));

    // R2
    short_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == 3'd0) |=> (new_cs == $past(cur_cs) && !cs_changed));

endmodule

bind jump_target_gen jtg_checker #(.OFS_W(OFS_W), .SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .kind       (kind),
    .cur_cs     (cur_cs),
    .operand    (operand),
    .out_valid  (out_valid),
    .new_cs     (new_cs),
    .new_ip     (new_ip),
    .cs_changed (cs_changed)
);

// File: tb/sim_jump_target_gen.sv
module sim_jump_target_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 5000;
    localparam int NV         = 12;

    // fields: kind, cur_cs, cur_ip, imm_bytes, operand, exp_cs, exp_ip, exp_flag
    localparam logic [131:0] VEC [NV] = '{
        {3'd0, 16'h2000, 16'h1000, 32'h0000_0004, 32'h0, 16'h2000, 16'h1006, 1'b0}, // R2 forward
        {3'd0, 16'h2000, 16'h1000, 32'h0000_0080, 32'h0, 16'h2000, 16'h0F82, 1'b0}, // R2 -128
        {3'd0, 16'h3000, 16'hFFFE, 32'h0000_0005, 32'h0, 16'h3000, 16'h0005, 1'b0}, // R8 up-wrap
        {3'd0, 16'h3000, 16'h0001, 32'h0000_00FB, 32'h0, 16'h3000, 16'hFFFE, 1'b0}, // R8 down-wrap
        {3'd1, 16'h2000, 16'h1000, 32'h0000_0002, 32'h0, 16'h2000, 16'h1005, 1'b0}, // R3
        {3'd1, 16'h4000, 16'h0100, 32'h0000_FF00, 32'h0, 16'h4000, 16'h0003, 1'b0}, // R3 negative
        {3'd1, 16'h4000, 16'hFFF0, 32'h0000_0020, 32'h0, 16'h4000, 16'h0013, 1'b0}, // R8 near wrap
        {3'd2, 16'h2000, 16'h1000, 32'h5678_1234, 32'h0, 16'h5678, 16'h1234, 1'b1}, // R4
        {3'd3, 16'h2000, 16'h1000, 32'hFFFF_FFFF, 32'h1234_ABCD, 16'h2000, 16'hABCD, 1'b0}, // R5
        {3'd4, 16'h2100, 16'h0500, 32'h0, 32'hDEAD_0042, 16'h2100, 16'h0042, 1'b0}, // R6
        {3'd5, 16'h2100, 16'h0500, 32'h0, 32'hF000_E05B, 16'hF000, 16'hE05B, 1'b1}, // R7
        {3'd1, 16'h0000, 16'h0000, 32'h0000_0180, 32'h0, 16'h0000, 16'h0183, 1'b0}  // R3 byte order
    };
    localparam int VREQ [NV] = '{2, 2, 8, 8, 3, 3, 8, 4, 5, 6, 7, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  kind = '0;
    logic [15:0] cur_cs = '0, cur_ip = '0;
    logic [31:0] imm_bytes = '0, operand = '0;
    logic        out_valid, cs_changed;
    logic [15:0] new_cs, new_ip;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jump_target_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .kind(kind),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .imm_bytes(imm_bytes), .operand(operand),
        .out_valid(out_valid), .new_cs(new_cs), .new_ip(new_ip), .cs_changed(cs_changed)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic v, input logic [15:0] cs,
                             input logic [15:0] ip, input logic fl);
        chk(req, "out_valid", 32'(out_valid), 32'(v));
        chk(req, "new_cs", 32'(new_cs), 32'(cs));
        chk(req, "new_ip", 32'(new_ip), 32'(ip));
        chk(req, "cs_changed", 32'(cs_changed), 32'(fl));
    endtask

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, 16'h0, 16'h0, 1'b0);
        rst_n = 1'b1;

        // table walk, back-to-back requests
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0)
                check_all($sformatf("R%0d", VREQ[i-1]), 1'b1, VEC[i-1][32:17],
                          VEC[i-1][16:1], VEC[i-1][0]);
            in_valid  = 1'b1;
            kind      = VEC[i][131:129];
            cur_cs    = VEC[i][128:113];
            cur_ip    = VEC[i][112:97];
            imm_bytes = VEC[i][96:65];
            operand   = VEC[i][64:33];
        end
        @(negedge clk);
        check_all($sformatf("R%0d", VREQ[NV-1]), 1'b1, VEC[NV-1][32:17],
                  VEC[NV-1][16:1], VEC[NV-1][0]);

        // R7 far table entry then idle: outputs hold (R9)
        in_valid = 1'b1; kind = 3'd5; cur_cs = 16'h1111; operand = 32'hF000_E05B;
        @(negedge clk);
        check_all("R7", 1'b1, 16'hF000, 16'hE05B, 1'b1);
        in_valid = 1'b0; kind = 3'd0; cur_cs = 16'h7777; cur_ip = 16'h0000; imm_bytes = 32'h10;
        @(negedge clk);
        check_all("R9", 1'b0, 16'hF000, 16'hE05B, 1'b1);
        @(negedge clk);
        check_all("R9", 1'b0, 16'hF000, 16'hE05B, 1'b1);

        // R10 reserved codes ignored
        in_valid = 1'b1; kind = 3'd6; operand = 32'h0000_1111;
        @(negedge clk);
        check_all("R10", 1'b0, 16'hF000, 16'hE05B, 1'b1);
        kind = 3'd7;
        @(negedge clk);
        check_all("R10", 1'b0, 16'hF000, 16'hE05B, 1'b1);

        // R9 recovery after reserved codes: short from 7777:0000, disp 0x10
        kind = 3'd0;
        @(negedge clk);
        check_all("R9", 1'b1, 16'h7777, 16'h0012, 1'b0);
        in_valid = 1'b0;

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1", 1'b0, 16'h0, 16'h0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule